// File: doc/BRIEF.md
# Self-Starting Skip-Sequence Counter

A 4-bit synchronous counter that steps through twelve of the sixteen codes in a fixed order: 0, 1, 2, 3, 6, 7, 10, 11, 12, 13, 14, 15, and then back to 0. The codes 4, 5, 8 and 9 are never visited in normal counting. A parallel preset port can still force them, and the counter returns to the valid cycle by itself on the next enabled clock.

An active-low asynchronous clear sets the state to 0 at once. A synchronous preset strobe loads any 4-bit code. The preset wins over counting and works whether or not the enable is high. A flag output marks whether the present state belongs to the counting cycle.

Top module: `skip_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0 and valid_o is 1, with no clock edge needed.
- R2: With en_i high and load_i low, each rising clock edge moves a valid state to its successor in the order 0,1,2,3,6,7,10,11,12,13,14,15.
- R3: With en_i high and load_i low, state 15 is followed by state 0.
- R4: With en_i low and load_i low, count_o keeps its value across clock edges.
- R5: With load_i high, the next rising edge loads load_val_i into count_o, whatever en_i is and whatever the current state is. This includes the unused codes 4, 5, 8 and 9.
- R6: With en_i high and load_i low, an unused state moves to a valid one in a single clock: 4 and 5 go to 6, and 8 and 9 go to 10.
- R7: valid_o is 1 exactly when count_o is one of the twelve sequence codes, and 0 for 4, 5, 8 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous clear, active low |
| en_i | input | 1 | Count enable |
| load_i | input | 1 | Synchronous preset strobe; takes priority over counting |
| load_val_i | input | 4 | Preset value |
| count_o | output | 4 | Present state |
| valid_o | output | 1 | High when the state is a sequence code |

## Verification
The counter is run through two full laps from the cleared state. This shows the two skips (3 to 6 and 7 to 10) and the wrap from 15 to 0. It also checks that no step lands on an unused code. Next, each of the sixteen codes is preset in turn, and the state after one enabled clock is compared with the successor computed in the bench. This exhaustive sweep separates the recovery paths of the four unused codes from the normal steps. A preset with enable high shows that loading beats counting. An enable-low stretch shows that the state holds. A clear asserted between clock edges shows that it acts at once, without waiting for a clock.

// File: rtl/skip_pkg.sv
package skip_pkg;
  localparam int unsigned CNT_W    = 4;
  localparam int unsigned N_CODES  = 1 << CNT_W;
  localparam int unsigned N_SKIP   = 4;
  localparam logic [CNT_W-1:0] SKIP_CODES [N_SKIP] = '{4'd4, 4'd5, 4'd8, 4'd9};

  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/skip_valid.sv
module skip_valid
  import skip_pkg::*;
(
  input  cnt_t state_i,
  output logic valid_o
);
  logic [N_SKIP-1:0] hit;

  for (genvar g = 0; g < N_SKIP; g++) begin : g_skip
    assign hit[g] = (state_i == SKIP_CODES[g]);
  end

  assign valid_o = ~|hit;
endmodule

// File: rtl/skip_next.sv
module skip_next
  import skip_pkg::*;
(
  input  cnt_t state_i,
  output cnt_t next_o
);
  always_comb begin
    unique case (state_i)
      4'd3, 4'd4, 4'd5: next_o = 4'd6;   // skip and recovery into 6
      4'd7, 4'd8, 4'd9: next_o = 4'd10;  // skip and recovery into 10
      4'd15:            next_o = 4'd0;
      default:          next_o = state_i + 4'd1;
    endcase
  end
endmodule

// File: rtl/skip_counter.sv
module skip_counter
  import skip_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             valid_o
);
  cnt_t state_q, state_nxt;

  skip_next u_next (
    .state_i (state_q),
    .next_o  (state_nxt)
  );

  skip_valid u_valid (
    .state_i (state_q),
    .valid_o (valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= '0;
    else if (load_i) state_q <= load_val_i;
    else if (en_i)   state_q <= state_nxt;
  end

  assign count_o = state_q;

  AST_RESET_CLEAR: assert property (@(posedge clk_i) !rst_ni |-> count_o == '0); // R1
  AST_STEP_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && valid_o && count_o != 4'd15) |=> count_o > $past(count_o)); // R2
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && count_o == 4'd15) |=> count_o == '0); // R3
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(count_o)); // R4
  AST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_val_i)); // R5
  AST_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && !valid_o) |=> valid_o); // R6
  AST_NO_UNUSED_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> valid_o); // R7
endmodule

// File: tb/tb_skip_counter.sv
module tb_skip_counter;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       load_i = 1'b0;
  logic [3:0] load_val_i = '0;
  logic [3:0] count_o;
  logic       valid_o;

  int n_checks = 0;
  int n_fail = 0;

  skip_counter dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .count_o    (count_o),
    .valid_o    (valid_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [3:0] succ(input logic [3:0] v);
    if (v == 4'd4 || v == 4'd5) return 4'd6;
    if (v == 4'd8 || v == 4'd9) return 4'd10;
    if (v == 4'd3) return 4'd6;
    if (v == 4'd7) return 4'd10;
    return v + 4'd1;  // 15 wraps to 0 by width
  endfunction

  function automatic logic in_seq(input logic [3:0] v);
    return !(v == 4'd4 || v == 4'd5 || v == 4'd8 || v == 4'd9);
  endfunction

  task automatic check(input string req, input logic [3:0] exp_cnt);
    n_checks++;
    if (count_o !== exp_cnt || valid_o !== in_seq(exp_cnt)) begin
      n_fail++;
      $display("FAIL %s: count=%0d valid=%0b expected count=%0d valid=%0b",
               req, count_o, valid_o, exp_cnt, in_seq(exp_cnt));
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [3:0] exp_v;
    #3;
    check("R1 reset", 4'd0);
    tick();
    check("R1 reset held", 4'd0);
    rst_ni = 1'b1;
    en_i = 1'b1;
    exp_v = 4'd0;
    // two laps: R2 order, R3 wrap, R7 flag
    for (int i = 0; i < 24; i++) begin
      tick();
      exp_v = succ(exp_v);
      check(exp_v == 4'd0 ? "R3 wrap" : "R2 R7 step", exp_v);
    end
    // R4 hold
    en_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R4 hold", exp_v);
    end
    // R5 R6 R7 exhaustive preset sweep
    for (int c = 0; c < 16; c++) begin
      load_i = 1'b1;
      load_val_i = 4'(c);
      en_i = c[0];
      tick();
      check("R5 R7 preset", 4'(c));
      load_i = 1'b0;
      en_i = 1'b1;
      tick();
      check(in_seq(4'(c)) ? "R2 step after preset" : "R6 recover", succ(4'(c)));
    end
    // R5 preset over counting with enable high
    load_i = 1'b1;
    load_val_i = 4'd9;
    tick();
    check("R5 preset priority", 4'd9);
    load_i = 1'b0;
    en_i = 1'b0;
    tick();
    check("R4 hold unused", 4'd9);
    // R1 async clear between edges
    #2;
    rst_ni = 1'b0;
    #1;
    check("R1 async clear", 4'd0);
    rst_ni = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule